// File: doc/BRIEF.md
# Configurable Handshake Channel Register Slice

This block is a pipeline stage for one valid/ready channel. It moves a payload, made of data bits and user sideband bits, from an upstream port to a downstream port. Typical uses are placing it on a single channel of a memory-mapped interconnect, or on any streaming link where a long combinational path has to be cut.

A compile-time mode parameter picks one of four variants:

- **Bypass**: plain wires, no storage.
- **Forward**: one output register. It cuts the valid and payload path.
- **Reverse**: a one-entry skid buffer. It cuts the ready path.
- **Full**: a skid buffer feeding an output register. It cuts both directions.

In every mode, beats leave in the order they arrived, each exactly once, whatever backpressure pattern is applied.

Top module: `chan_reg_slice`

## Requirements
- R1: With MODE = bypass, `dn_valid` equals `up_valid`, `up_ready` equals `dn_ready`, and the downstream payload equals the upstream payload in the same cycle.
- R2: With MODE = forward, a beat accepted at a clock edge is presented on the downstream port from the next cycle, from registers. `up_ready` is high exactly when the stage is empty or `dn_ready` is high.
- R3: With MODE = reverse, `up_ready` is low exactly when the skid entry holds a beat. When the entry is empty, the upstream beat appears downstream in the same cycle. A beat offered while `dn_ready` is low is captured, and `up_ready` drops on the next cycle.
- R4: With MODE = full, an accepted beat appears downstream no earlier than the next cycle. `up_ready` is low only while two beats are held. `dn_valid` is high whenever at least one beat is held.
- R5: In every mode, the sequence of beats handed over downstream equals the sequence accepted upstream: none lost, duplicated or reordered.
- R6: The user sideband bits travel with their data beat in every mode.
- R7: A synchronous active-low reset empties all storage. While reset is held and after its release with no new input, `dn_valid` is low and `up_ready` is high (the bypass mode has no storage).
- R8: While `dn_valid` is high and `dn_ready` is low, the downstream payload and `dn_valid` remain unchanged on the next cycle.
- R9: With `up_valid` and `dn_ready` both held high, every mode passes one beat per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream beat offered |
| up_ready | output | 1 | Slice can take the upstream beat |
| up_data | input | DATA_W | Upstream data bits |
| up_user | input | USER_W | Upstream user sideband bits |
| dn_valid | output | 1 | Downstream beat offered |
| dn_ready | input | 1 | Downstream sink takes the beat |
| dn_data | output | DATA_W | Downstream data bits |
| dn_user | output | USER_W | Downstream user sideband bits |

## Verification
The stability and latency properties assume that the upstream side obeys the usual handshake rule: once `up_valid` is raised, it stays high, with an unchanged payload, until `up_ready` is seen high. The stimulus meets this rule by driving each slice instance from its own source. A source draws a new random beat only after the previous one has been accepted, and otherwise holds valid and payload as they were. The downstream ready, by contrast, is free to toggle every cycle, because the slice must tolerate any sink behaviour.

// File: rtl/chs_pkg.sv
package chs_pkg;
    typedef enum logic [1:0] {
        CHS_BYPASS  = 2'd0,
        CHS_FORWARD = 2'd1,
        CHS_REVERSE = 2'd2,
        CHS_FULL    = 2'd3
    } chs_mode_e;
endpackage

// File: rtl/chs_fwd_stage.sv
module chs_fwd_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_pay
);
    typedef struct packed {
        logic             vld;
        logic [PAY_W-1:0] pay;
    } fwd_st_t;

    fwd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        if (in_valid && in_ready) begin
            st_d.vld = 1'b1;
            st_d.pay = in_pay;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pay   = st_q.pay;

    AST_FWD_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_pay == $past(in_pay)); // R2
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pay)); // R8
    AST_FWD_RST_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R7
endmodule

// File: rtl/chs_skid_stage.sv
module chs_skid_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_pay
);
    typedef struct packed {
        logic             full;
        logic [PAY_W-1:0] pay;
    } skid_st_t;

    skid_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        in_ready  = !st_q.full;
        out_valid = st_q.full || in_valid;
        out_pay   = st_q.full ? st_q.pay : in_pay;
        if (st_q.full) begin
            if (out_ready) st_d.full = 1'b0;
        end else if (in_valid && !out_ready) begin
            st_d.full = 1'b1;
            st_d.pay  = in_pay;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SKID_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !out_ready |=> !in_ready); // R3
    AST_SKID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pay)); // R8
    AST_SKID_RST_RDY: assert property (@(posedge clk)
        !rst_n |=> in_ready); // R7
endmodule

// File: rtl/chan_reg_slice.sv
module chan_reg_slice #(
    parameter int                 DATA_W = 16,
    parameter int                 USER_W = 2,
    parameter chs_pkg::chs_mode_e MODE   = chs_pkg::CHS_FULL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic [USER_W-1:0] up_user,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data,
    output logic [USER_W-1:0] dn_user
);
    localparam int PAY_W = DATA_W + USER_W;

    logic [PAY_W-1:0] in_pay;
    logic [PAY_W-1:0] out_pay;

    assign in_pay             = {up_user, up_data};
    assign {dn_user, dn_data} = out_pay;

    generate
        case (MODE)
            chs_pkg::CHS_BYPASS: begin : g_bypass
                assign dn_valid = up_valid;
                assign up_ready = dn_ready;
                assign out_pay  = in_pay;
            end
            chs_pkg::CHS_FORWARD: begin : g_forward
                chs_fwd_stage #(.PAY_W(PAY_W)) u_fwd (
                    .clk(clk), .rst_n(rst_n),
                    .in_valid(up_valid), .in_ready(up_ready), .in_pay(in_pay),
                    .out_valid(dn_valid), .out_ready(dn_ready), .out_pay(out_pay)
                );
            end
            chs_pkg::CHS_REVERSE: begin : g_reverse
                chs_skid_stage #(.PAY_W(PAY_W)) u_skid (
                    .clk(clk), .rst_n(rst_n),
                    .in_valid(up_valid), .in_ready(up_ready), .in_pay(in_pay),
                    .out_valid(dn_valid), .out_ready(dn_ready), .out_pay(out_pay)
                );
            end
            default: begin : g_full
                logic             mid_valid;
                logic             mid_ready;
                logic [PAY_W-1:0] mid_pay;

                chs_skid_stage #(.PAY_W(PAY_W)) u_skid (
                    .clk(clk), .rst_n(rst_n),
                    .in_valid(up_valid), .in_ready(up_ready), .in_pay(in_pay),
                    .out_valid(mid_valid), .out_ready(mid_ready), .out_pay(mid_pay)
                );
                chs_fwd_stage #(.PAY_W(PAY_W)) u_fwd (
                    .clk(clk), .rst_n(rst_n),
                    .in_valid(mid_valid), .in_ready(mid_ready), .in_pay(mid_pay),
                    .out_valid(dn_valid), .out_ready(dn_ready), .out_pay(out_pay)
                );

                AST_FULL_MIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
                    up_valid && up_ready && !dn_valid |=> dn_valid); // R4
            end
        endcase
    endgenerate
endmodule

// File: tb/chan_reg_slice_tb.sv
module chan_reg_slice_tb;
    import chs_pkg::*;

    localparam int DW = 16;
    localparam int UW = 2;
    localparam int PW = DW + UW;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          uv [NL];
    logic          ur [NL];
    logic [DW-1:0] ud [NL];
    logic [UW-1:0] uu [NL];
    logic          dv [NL];
    logic [DW-1:0] dd [NL];
    logic [UW-1:0] du [NL];
    logic          dr;

    chan_reg_slice #(.DATA_W(DW), .USER_W(UW), .MODE(CHS_BYPASS)) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .up_valid(uv[0]), .up_ready(ur[0]), .up_data(ud[0]),
        .up_user(uu[0]), .dn_valid(dv[0]), .dn_ready(dr), .dn_data(dd[0]), .dn_user(du[0]));
    chan_reg_slice #(.DATA_W(DW), .USER_W(UW), .MODE(CHS_FORWARD)) u_dut_fwd (
        .clk(clk), .rst_n(rst_n), .up_valid(uv[1]), .up_ready(ur[1]), .up_data(ud[1]),
        .up_user(uu[1]), .dn_valid(dv[1]), .dn_ready(dr), .dn_data(dd[1]), .dn_user(du[1]));
    chan_reg_slice #(.DATA_W(DW), .USER_W(UW), .MODE(CHS_REVERSE)) u_dut_rev (
        .clk(clk), .rst_n(rst_n), .up_valid(uv[2]), .up_ready(ur[2]), .up_data(ud[2]),
        .up_user(uu[2]), .dn_valid(dv[2]), .dn_ready(dr), .dn_data(dd[2]), .dn_user(du[2]));
    chan_reg_slice #(.DATA_W(DW), .USER_W(UW), .MODE(CHS_FULL)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_valid(uv[3]), .up_ready(ur[3]), .up_data(ud[3]),
        .up_user(uu[3]), .dn_valid(dv[3]), .dn_ready(dr), .dn_data(dd[3]), .dn_user(du[3]));

    int checks = 0;
    int errors = 0;
    int tx   [NL];
    int rx   [NL];
    int tput [NL];
    bit hold [NL];
    logic [PW-1:0] q1[$];
    logic [PW-1:0] q2[$];
    logic [PW-1:0] q3[$];

    function automatic logic [PW-1:0] gen(int n);
        logic [PW-1:0] r;
        r[DW-1:0]    = DW'(n);
        r[PW-1:DW]   = UW'(n) ^ {UW{1'b1}};
        return r;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step(int vpct, int rpct, bit count_tput);
        @(negedge clk);
        dr = (($urandom % 100) < rpct);
        for (int i = 0; i < NL; i++) begin
            if (!hold[i]) begin
                uv[i] = (($urandom % 100) < vpct);
                {uu[i], ud[i]} = gen(tx[i]);
            end
        end
        #3;
        for (int i = 0; i < NL; i++) begin
            logic [PW-1:0] pup;
            logic [PW-1:0] pdn;
            int cnt;
            pup = {uu[i], ud[i]};
            pdn = {du[i], dd[i]};
            case (i)
                0: begin
                    chk("R1", "bypass ready", 32'(ur[0]), 32'(dr));
                    chk("R1", "bypass valid", 32'(dv[0]), 32'(uv[0]));
                    chk("R1", "bypass payload", 32'(pdn), 32'(pup));
                end
                1: begin
                    cnt = q1.size();
                    chk("R2", "fwd ready", 32'(ur[1]), 32'(cnt == 0 || dr));
                    chk("R2", "fwd valid", 32'(dv[1]), 32'(cnt > 0));
                    if (cnt > 0) chk("R8", "fwd payload", 32'(pdn), 32'(q1[0]));
                end
                2: begin
                    cnt = q2.size();
                    chk("R3", "rev ready", 32'(ur[2]), 32'(cnt == 0));
                    chk("R3", "rev valid", 32'(dv[2]), 32'(cnt > 0 || uv[2]));
                    if (cnt > 0)      chk("R8", "rev held payload", 32'(pdn), 32'(q2[0]));
                    else if (uv[2])   chk("R3", "rev pass payload", 32'(pdn), 32'(pup));
                end
                default: begin
                    cnt = q3.size();
                    chk("R4", "full ready", 32'(ur[3]), 32'(cnt < 2));
                    chk("R4", "full valid", 32'(dv[3]), 32'(cnt > 0));
                    if (cnt > 0) chk("R8", "full payload", 32'(pdn), 32'(q3[0]));
                end
            endcase
            if (dv[i] && dr) begin
                chk("R5", "beat order data", 32'(pdn[DW-1:0]), 32'(gen(rx[i]) & {UW'(0), {DW{1'b1}}}));
                chk("R6", "beat user bits", 32'(pdn[PW-1:DW]), 32'(gen(rx[i]) >> DW));
                rx[i]++;
                if (count_tput) tput[i]++;
            end
            if (uv[i] && ur[i]) tx[i]++;
            case (i)
                1: begin
                    if (dv[1] && dr && q1.size() > 0) void'(q1.pop_front());
                    if (uv[1] && ur[1]) q1.push_back(pup);
                end
                2: begin
                    if (q2.size() > 0) begin
                        if (dr) void'(q2.pop_front());
                    end else if (uv[2] && !dr) begin
                        q2.push_back(pup);
                    end
                end
                3: begin
                    if (dv[3] && dr && q3.size() > 0) void'(q3.pop_front());
                    if (uv[3] && ur[3]) q3.push_back(pup);
                end
                default: ;
            endcase
            hold[i] = uv[i] && !ur[i];
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        dr = 1'b0;
        for (int i = 0; i < NL; i++) begin
            uv[i] = 1'b0; ud[i] = '0; uu[i] = '0;
            tx[i] = 0; rx[i] = 0; tput[i] = 0; hold[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        #3;
        // R7: state during reset with no input and sink stalled
        for (int i = 1; i < NL; i++) begin
            chk("R7", "reset dn_valid", 32'(dv[i]), 32'd0);
            chk("R7", "reset up_ready", 32'(ur[i]), 32'd1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #3;
        for (int i = 1; i < NL; i++) begin
            chk("R7", "post-reset dn_valid", 32'(dv[i]), 32'd0);
            chk("R7", "post-reset up_ready", 32'(ur[i]), 32'd1);
        end
        // R9: streaming with both sides always ready
        for (int c = 0; c < 200; c++) step(100, 100, c >= 10);
        for (int i = 0; i < NL; i++)
            chk("R9", "beats per 190 cycles", 32'(tput[i]), 32'd190);
        // random backpressure, several densities
        for (int c = 0; c < 1500; c++) step(60, 50, 1'b0);
        for (int c = 0; c < 800; c++)  step(90, 20, 1'b0);
        for (int c = 0; c < 30; c++)   step(100, 0, 1'b0);
        for (int c = 0; c < 800; c++)  step(30, 90, 1'b0);
        // drain: sources finish their pending beats, sink always ready
        for (int c = 0; c < 40; c++)   step(hold[0] ? 100 : 0, 100, 1'b0);
        for (int c = 0; c < 10; c++)   step(0, 100, 1'b0);
        for (int i = 0; i < NL; i++)
            chk("R5", "beats out equals beats in", 32'(rx[i]), 32'(tx[i]));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule